// File: doc/BRIEF.md
# Oversampled serial receiver with per-character error status

This block turns an asynchronous serial line into 12-bit receive words. It counts oversampling ticks supplied from outside, at 16 per bit by default. It confirms a start bit in the middle of that bit and then samples each data bit, the optional parity bit and one stop bit at their centres. Each finished character is written into a receive buffer together with four error flags: framing, parity, break and overrun. The buffer is either a FIFO of `DEPTH` entries or, when the FIFO is turned off, a single holding slot.

The buffer is drained through a valid/ready read stream. `rd_valid` is high whenever an entry is stored, and `rd_data` shows the oldest entry. That entry is removed on a clock edge where both `rd_valid` and `rd_ready` are high. While `rd_ready` is low, the head entry stays in place and keeps its data and error bits. The serial side cannot be held off. When a character arrives with no room for it, that is an overrun.

A separate 4-bit status register keeps the framing, parity and break flags of the character most recently read. It keeps an overrun flag that is set the moment an overrun happens. A one-cycle `stat_clr` pulse clears all four bits. The `rx_empty` and `rx_full` flags report the buffer level. When flow control is enabled, `rts_out` requests more data only while there is room for it.

Top module: `uart_rx_core`

## Requirements
- R1: After a falling edge on the line, the start bit is re-sampled 8 ticks later and must still be low. The data bits follow LSB first, each sampled 16 ticks after the previous sample. `word_len` selects 5, 6, 7 or 8 data bits for codes 00, 01, 10 and 11. Data bits above the word length read as 0.
- R2: A stored word has data in [7:0], framing error in bit 8, parity error in bit 9, break in bit 10 and overrun in bit 11. An entry is removed only on a `rd_valid && rd_ready` edge. While `rd_ready` is low, `rd_valid` stays high and bits [10:0] of `rd_data` hold still.
- R3: With `parity_en`=1, the expected parity bit depends on the mode. When `stick_sel`=0 and `even_sel`=1, the expected bit makes the count of ones even. When `stick_sel`=0 and `even_sel`=0, it makes the count odd. When `stick_sel`=1, the expected bit is 0 if `even_sel`=1 and 1 if `even_sel`=0. A mismatch sets bit 9.
- R4: A low first stop bit sets bit 8. Only one stop bit is checked, so a start bit that follows the first stop bit at once is received correctly.
- R5: If the line stays low through the start, data, parity and stop positions, exactly one entry 0x400 is stored. No new frame starts until the line has gone high again.
- R6: Status bit 0 is framing, bit 1 is parity, bit 2 is break and bit 3 is overrun, and all are 0 after reset. Bits 0–2 are loaded from bits 8–10 of an entry when that entry is read. Without a read they do not change.
- R7: If a character completes while the buffer is full and nothing is read in that cycle, the character is dropped. Bit 11 of the newest stored entry is set. Status bit 3 is 1 on the next cycle, with no read needed.
- R8: A `stat_clr` pulse clears all four status bits.
- R9: The buffer holds `DEPTH` entries when `fifo_en`=1 and one entry when `fifo_en`=0. `rx_empty` is 1 when nothing is stored and `rx_full` is 1 when the buffer is at capacity. After reset, `rx_empty`=1 and `rx_full`=0.
- R10: With `rts_fc_en`=1, `rts_out` equals the inverse of `rx_full`. With `rts_fc_en`=0, `rts_out` is 1.
- R11: While `rx_en`=0, no new frame is started, and a frame sent on the line leaves the buffer empty.
- R12: In FIFO mode, entries are read out in the order they were received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit period |
| rx_in | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Allows new frames to start |
| fifo_en | input | 1 | 1 = FIFO of DEPTH entries, 0 = single holding slot |
| word_len | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| parity_en | input | 1 | A parity bit follows the data |
| even_sel | input | 1 | Even parity (or stick value 0) |
| stick_sel | input | 1 | Stick parity |
| rts_fc_en | input | 1 | Flow control enable for rts_out |
| rd_valid | output | 1 | A stored word is available |
| rd_ready | input | 1 | Consumer accepts rd_data |
| rd_data | output | 12 | Oldest stored word with its error bits |
| stat_clr | input | 1 | Clears the status register |
| stat_q | output | 4 | Sticky receive status |
| rx_empty | output | 1 | Buffer empty |
| rx_full | output | 1 | Buffer at capacity |
| rts_out | output | 1 | Request to send, high = send more |

## Verification
Clean characters are sent at all four word lengths, with data set in bits above the word length, to separate correct bit placement from sampling at the wrong width. A wrong parity bit, a low stop bit and a line held low produce the three error entries. Each error is checked both in the stored word and in the status register, before and after the read, which shows apart status loaded on the read from status loaded on arrival. Back-to-back frames with no idle gap and a second character into a full holding slot test the single stop-bit check and the overrun rule. A full FIFO read out under back-pressure tests ordering and that the head entry holds while it waits to be read.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef struct packed {
    logic       ovr;
    logic       brk;
    logic       par_err;
    logic       frm_err;
    logic [7:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAIT_HIGH
  } rx_state_t;

endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rx_in,
  input  logic      rx_en,
  input  logic [1:0] word_len,
  input  logic      parity_en,
  input  logic      even_sel,
  input  logic      stick_sel,
  output logic      push,
  output rx_entry_t entry
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  rx_state_t              state;
  logic [CNT_W-1:0]       cnt;
  logic [2:0]             idx;
  logic [2:0]             last_idx;
  logic [7:0]             shreg;
  logic                   all_low;
  logic                   par_bad;
  logic                   exp_par;

  // line synchronizer, length picked by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= rx_in;
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
    end
  endgenerate
  assign rx_s = sync_q[SYNC_STAGES-1];

  assign last_idx = 3'd4 + {1'b0, word_len};

  always_comb begin
    if (stick_sel)     exp_par = ~even_sel;
    else if (even_sel) exp_par = ^shreg;
    else               exp_par = ~(^shreg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      all_low <= 1'b0;
      par_bad <= 1'b0;
      push    <= 1'b0;
      entry   <= '0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        unique case (state)
          ST_IDLE: begin
            if (rx_en && !rx_s) begin
              state <= ST_START;
              cnt   <= '0;
            end
          end
          ST_START: begin
            if (cnt == MID) begin
              cnt <= '0;
              if (!rx_s) begin
                state   <= ST_DATA;
                idx     <= '0;
                shreg   <= '0;
                all_low <= 1'b1;
                par_bad <= 1'b0;
              end else begin
                state <= ST_IDLE;
              end
            end else cnt <= cnt + 1'b1;
          end
          ST_DATA: begin
            if (cnt == LAST) begin
              cnt        <= '0;
              shreg[idx] <= rx_s;
              all_low    <= all_low & ~rx_s;
              if (idx == last_idx) state <= parity_en ? ST_PAR : ST_STOP;
              else                 idx   <= idx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          ST_PAR: begin
            if (cnt == LAST) begin
              cnt     <= '0;
              par_bad <= (rx_s != exp_par);
              all_low <= all_low & ~rx_s;
              state   <= ST_STOP;
            end else cnt <= cnt + 1'b1;
          end
          ST_STOP: begin
            if (cnt == LAST) begin
              cnt  <= '0;
              push <= 1'b1;
              if (all_low && !rx_s) begin
                entry.data    <= '0;
                entry.frm_err <= 1'b0;
                entry.par_err <= 1'b0;
                entry.brk     <= 1'b1;
                entry.ovr     <= 1'b0;
              end else begin
                entry.data    <= shreg;
                entry.frm_err <= ~rx_s;
                entry.par_err <= par_bad;
                entry.brk     <= 1'b0;
                entry.ovr     <= 1'b0;
              end
              state <= rx_s ? ST_IDLE : ST_WAIT_HIGH;
            end else cnt <= cnt + 1'b1;
          end
          ST_WAIT_HIGH: begin
            if (rx_s) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fifo_en,
  input  logic      push,
  input  rx_entry_t push_entry,
  input  logic      pop,
  output rx_entry_t head,
  output logic      empty,
  output logic      full,
  output logic      ovr
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  rx_entry_t       mem [DEPTH];
  logic [AW-1:0]   wr_ptr;
  logic [AW-1:0]   rd_ptr;
  logic [CW-1:0]   count;
  logic [CW-1:0]   cap;
  logic            accept;

  assign cap    = fifo_en ? CW'(DEPTH) : CW'(1);
  assign empty  = (count == '0);
  assign full   = (count >= cap);
  assign accept = push && (!full || pop);
  assign ovr    = push && full && !pop;
  assign head   = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) begin
        mem[wr_ptr] <= push_entry;
        wr_ptr      <= wr_ptr + 1'b1;
      end
      if (ovr) mem[wr_ptr - AW'(1)].ovr <= 1'b1;
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      case ({accept, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       pop,
  input  logic [3:0] head_err,
  input  logic       ovr_now,
  output logic [3:0] stat
);
  logic [3:0] nxt;

  always_comb begin
    nxt = stat;
    if (clr) nxt = '0;
    if (pop) begin
      nxt[2:0] = head_err[2:0];
      nxt[3]   = nxt[3] | head_err[3];
    end
    if (ovr_now) nxt[3] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stat <= '0;
    else        stat <= nxt;
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int OVERSAMPLE = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick16,
  input  logic        rx_in,
  input  logic        rx_en,
  input  logic        fifo_en,
  input  logic [1:0]  word_len,
  input  logic        parity_en,
  input  logic        even_sel,
  input  logic        stick_sel,
  input  logic        rts_fc_en,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [11:0] rd_data,
  input  logic        stat_clr,
  output logic [3:0]  stat_q,
  output logic        rx_empty,
  output logic        rx_full,
  output logic        rts_out
);
  rx_entry_t new_entry;
  rx_entry_t head;
  logic      push_w;
  logic      pop_w;
  logic      ovr_w;

  uart_rx_deser #(.OVERSAMPLE(OVERSAMPLE), .SYNC_STAGES(2)) u_deser (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rx_in(rx_in), .rx_en(rx_en),
    .word_len(word_len), .parity_en(parity_en), .even_sel(even_sel),
    .stick_sel(stick_sel), .push(push_w), .entry(new_entry)
  );

  uart_rx_buf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push(push_w),
    .push_entry(new_entry), .pop(pop_w), .head(head), .empty(rx_empty),
    .full(rx_full), .ovr(ovr_w)
  );

  assign rd_valid = !rx_empty;
  assign pop_w    = rd_valid && rd_ready;
  assign rd_data  = head;
  assign rts_out  = !rts_fc_en || !rx_full;

  uart_rx_status u_stat (
    .clk(clk), .rst_n(rst_n), .clr(stat_clr), .pop(pop_w),
    .head_err(rd_data[11:8]), .ovr_now(ovr_w), .stat(stat_q)
  );
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [11:0] rd_data,
  input logic [3:0]  stat_q,
  input logic        stat_clr,
  input logic        rx_empty,
  input logic        rx_full,
  input logic        rts_out,
  input logic        rts_fc_en,
  input logic        pop,
  input logic        ovr
);
  // R2: head entry waits under back-pressure
  a_r2_hold_head: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data[10:0])));

  // R6: status moves only on a read, a clear or an overrun
  a_r6_stat_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop && !stat_clr && !ovr) |=> $stable(stat_q));

  // R7: overrun reaches status on the next cycle
  a_r7_ovr_status: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> stat_q[3]);

  // R8: clear empties status
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !pop && !ovr) |=> (stat_q == 4'b0000));

  // R9: empty buffer offers nothing and is not full
  a_r9_empty_flags: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> (!rd_valid && !rx_full));

  // R10: flow control output follows fill state
  a_r10_rts_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_fc_en && rx_full) |-> !rts_out);
  a_r10_rts_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_fc_en |-> rts_out);
endmodule

bind uart_rx_core uart_rx_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .stat_q(stat_q), .stat_clr(stat_clr),
  .rx_empty(rx_empty), .rx_full(rx_full), .rts_out(rts_out),
  .rts_fc_en(rts_fc_en), .pop(pop_w), .ovr(ovr_w)
);

// File: tb/uart_rx_core_tb.sv
`timescale 1ns/1ps
module uart_rx_core_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tick16 = 1;
  logic        rx_in = 1;
  logic        rx_en = 1;
  logic        fifo_en = 1;
  logic [1:0]  word_len = 2'b11;
  logic        parity_en = 0;
  logic        even_sel = 0;
  logic        stick_sel = 0;
  logic        rts_fc_en = 0;
  logic        rd_ready = 0;
  logic        stat_clr = 0;
  logic        rd_valid;
  logic [11:0] rd_data;
  logic [3:0]  stat_q;
  logic        rx_empty, rx_full, rts_out;
  int checks = 0;
  int errors = 0;

  uart_rx_core #(.DEPTH(16), .OVERSAMPLE(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in), .rx_en(rx_en),
    .fifo_en(fifo_en), .word_len(word_len), .parity_en(parity_en),
    .even_sel(even_sel), .stick_sel(stick_sel), .rts_fc_en(rts_fc_en),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .stat_clr(stat_clr), .stat_q(stat_q), .rx_empty(rx_empty),
    .rx_full(rx_full), .rts_out(rts_out)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    rx_in = b;
    wait_n(16);
  endtask

  task automatic send_char(input logic [7:0] d, input int nb, input bit with_par,
                           input logic pbit, input logic stopb);
    bit_out(1'b0);
    for (int i = 0; i < nb; i++) bit_out(d[i]);
    if (with_par) bit_out(pbit);
    bit_out(stopb);
    rx_in = 1'b1;
  endtask

  task automatic do_read(output logic [11:0] d);
    d = rd_data;
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic pulse_clr();
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
  endtask

  function automatic logic par_of(input logic [7:0] d, input int nb, input logic ev, input logic st);
    logic ones;
    ones = 1'b0;
    for (int i = 0; i < nb; i++) ones ^= d[i];
    if (st) return ~ev;
    return ev ? ones : ~ones;
  endfunction

  task automatic t_reset();
    chk("R9 reset empty", {11'd0, rx_empty}, 12'd1);
    chk("R9 reset full", {11'd0, rx_full}, 12'd0);
    chk("R6 reset status", {8'd0, stat_q}, 12'd0);
    chk("R10 rts idle", {11'd0, rts_out}, 12'd1);
  endtask

  task automatic t_basic();
    logic [11:0] d;
    word_len = 2'b11;
    send_char(8'hA5, 8, 0, 0, 1); wait_n(6);
    chk("R2 valid after char", {11'd0, rd_valid}, 12'd1);
    do_read(d); chk("R1 8-bit char", d, 12'h0A5);
    word_len = 2'b00;
    send_char(8'hFF, 5, 0, 0, 1); wait_n(6);
    do_read(d); chk("R1 5-bit upper zero", d, 12'h01F);
    word_len = 2'b01;
    send_char(8'h2A, 6, 0, 0, 1); wait_n(6);
    do_read(d); chk("R1 6-bit char", d, 12'h02A);
    word_len = 2'b11;
  endtask

  task automatic t_parity();
    logic [11:0] d;
    word_len = 2'b10; parity_en = 1; even_sel = 1; stick_sel = 0;
    send_char(8'h35, 7, 1, par_of(8'h35, 7, 1, 0), 1); wait_n(6);
    do_read(d); chk("R3 even ok", d, 12'h035);
    send_char(8'h35, 7, 1, ~par_of(8'h35, 7, 1, 0), 1); wait_n(6);
    chk("R6 status before read", {8'd0, stat_q}, 12'h000);
    do_read(d); chk("R3 even bad", d, 12'h235);
    chk("R6 status parity after read", {8'd0, stat_q}, 12'h002);
    even_sel = 0;
    send_char(8'h35, 7, 1, par_of(8'h35, 7, 0, 0), 1); wait_n(6);
    do_read(d); chk("R3 odd ok", d, 12'h035);
    chk("R6 status follows read", {8'd0, stat_q}, 12'h000);
    stick_sel = 1; even_sel = 1;
    send_char(8'h35, 7, 1, 1'b1, 1); wait_n(6);
    do_read(d); chk("R3 stick zero bad", d, 12'h235);
    even_sel = 0;
    send_char(8'h35, 7, 1, 1'b1, 1); wait_n(6);
    do_read(d); chk("R3 stick one ok", d, 12'h035);
    parity_en = 0; stick_sel = 0; word_len = 2'b11;
  endtask

  task automatic t_frame();
    logic [11:0] d;
    send_char(8'h5A, 8, 0, 0, 0); wait_n(40);
    do_read(d); chk("R4 framing bit", d, 12'h15A);
    chk("R6 status framing", {8'd0, stat_q}, 12'h001);
    pulse_clr();
    chk("R8 clear", {8'd0, stat_q}, 12'h000);
    send_char(8'h81, 8, 0, 0, 1);
    send_char(8'h7E, 8, 0, 0, 1); wait_n(6);
    do_read(d); chk("R4 back-to-back first", d, 12'h081);
    do_read(d); chk("R4 back-to-back second", d, 12'h07E);
  endtask

  task automatic t_break();
    logic [11:0] d;
    rx_in = 0; wait_n(250);
    rx_in = 1; wait_n(40);
    do_read(d); chk("R5 break entry", d, 12'h400);
    chk("R5 single entry", {11'd0, rx_empty}, 12'd1);
    chk("R6 status break", {8'd0, stat_q}, 12'h004);
    pulse_clr();
  endtask

  task automatic t_ovr();
    logic [11:0] d;
    fifo_en = 0; rts_fc_en = 1;
    send_char(8'h11, 8, 0, 0, 1); wait_n(6);
    chk("R9 holding full", {11'd0, rx_full}, 12'd1);
    chk("R10 rts dropped", {11'd0, rts_out}, 12'd0);
    send_char(8'h22, 8, 0, 0, 1); wait_n(6);
    chk("R7 overrun status early", {8'd0, stat_q}, 12'h008);
    do_read(d); chk("R7 newest marked", d, 12'h811);
    chk("R7 second dropped", {11'd0, rx_empty}, 12'd1);
    chk("R10 rts back", {11'd0, rts_out}, 12'd1);
    pulse_clr();
    fifo_en = 1;
  endtask

  task automatic t_fifo();
    logic [11:0] d;
    logic [11:0] h;
    for (int i = 0; i < 16; i++) send_char(8'(i * 7 + 3), 8, 0, 0, 1);
    wait_n(6);
    chk("R9 fifo full", {11'd0, rx_full}, 12'd1);
    chk("R10 rts full", {11'd0, rts_out}, 12'd0);
    rts_fc_en = 0; @(negedge clk);
    chk("R10 rts disabled", {11'd0, rts_out}, 12'd1);
    h = rd_data; wait_n(5);
    chk("R2 head held", rd_data, h);
    chk("R2 valid held", {11'd0, rd_valid}, 12'd1);
    for (int i = 0; i < 16; i++) begin
      do_read(d);
      chk("R12 fifo order", d, {4'h0, 8'(i * 7 + 3)});
    end
    chk("R9 drained", {11'd0, rx_empty}, 12'd1);
  endtask

  task automatic t_rxen();
    rx_en = 0;
    send_char(8'h3C, 8, 0, 0, 1); wait_n(6);
    chk("R11 disabled ignored", {11'd0, rx_empty}, 12'd1);
    rx_en = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(2);
    t_reset();
    t_basic();
    t_parity();
    t_frame();
    t_break();
    t_ovr();
    t_fifo();
    t_rxen();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule